// File: doc/BRIEF.md
# Oversampled Bit Synchronizer Data Interface

This block sits between a radio's modulator and demodulator on one side and a host controller on the other, and it owns the bit timing of the serial data exchanged between them. A mode bit selects one of two behaviours. In the transparent mode, host data goes straight to the modulator, raw demodulator data goes straight to the host, and the clock output stays low. In the timed mode the block is the timing master. When transmitting, it captures the host's bit on the rising edge of a bit-rate clock that it also drives out to the host. When receiving, it recovers the bit clock from a stream sampled at 16 times the bit rate. It samples each bit at mid-period and hands the host a retimed bit whose transitions fall only on rising edges of the recovered clock.

Everything runs on one system clock. A single-cycle strobe `os_tick` marks each sub-sample at 16 times the nominal bit rate, and the transmit bit clock is derived from the same strobe. Receive recovery puts the raw bit through a two-flop synchronizer and a five-tap majority vote. It then steers a sub-sample phase counter by one step per observed edge. A lock flag reports when edges have been landing near the expected bit boundary. The serial data has no back-pressure: in timed mode the host has to present transmit bits and sample receive bits on falling edges of `host_clk`, one bit per clock period. Changes to the mode or direction inputs are applied only at a bit boundary.

Top module: `bsync_data_if`

## Requirements
- R1: With `sync_en` applied as 0, `host_clk` is 0. In transmit (`tx_mode`=1) `mod_bit` equals `host_tx_bit` combinationally. In receive (`tx_mode`=0) `host_rx_bit` equals `demod_bit` combinationally. The output belonging to the unused direction is 0.
- R2: In timed transmit, `host_clk` has a period of 16 `os_tick` strobes and is high for the first 8 of them. `host_tx_bit` is captured at each rising edge of `host_clk`, and `mod_bit` holds that value for the whole bit period whatever the host does meanwhile.
- R3: In timed receive, each bit of an incoming stream at the nominal rate is presented on `host_rx_bit` once an alternating preamble has been received. The bit is sampled when the phase counter enters its mid count. `host_clk` is high during the second half of the recovered bit.
- R4: In timed receive, `host_rx_bit` changes only in the cycle in which `host_clk` rises.
- R5: Data is recovered correctly for incoming bit rates 2.5% above and 2.5% below nominal.
- R6: A 22-bit alternating preamble is enough to recover the data that follows, whatever the starting phase of the stream relative to the local counter.
- R7: Pulses of one or two sub-samples inside a bit do not change the recovered data.
- R8: `locked` rises only after 8 consecutive edges fall within ±2 sub-samples of the expected bit boundary. It falls after 16 bit periods with no edge, or when timed receive is left.
- R9: A change of `sync_en` or `tx_mode` takes effect only at a bit boundary, and the phase counter restarts from 0 at that boundary.
- R10: During and just after reset, the block is in transparent receive, with `host_clk`, `mod_bit` and `locked` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Sub-sample strobe, 16 per nominal bit |
| sync_en | input | 1 | 1 selects timed mode, 0 transparent |
| tx_mode | input | 1 | 1 transmit, 0 receive |
| host_tx_bit | input | 1 | Serial data from the host |
| host_rx_bit | output | 1 | Serial data to the host |
| host_clk | output | 1 | Bit clock to the host (low in transparent mode) |
| mod_bit | output | 1 | Bit driving the modulator |
| demod_bit | input | 1 | Raw bit from the demodulator |
| locked | output | 1 | Receive clock recovery is locked |

## Verification
The hardest case to reach from the ports is acquisition at the limit: a preamble of only 22 bits, starting at an unfavourable phase relative to the local counter, possibly at a bit rate 2.5% off. The bench builds the incoming stream with a fractional accumulator in fortieths of a sub-sample, so the rate offset builds up bit by bit. It starts the stream after idle gaps of several lengths so that the initial phase error covers the whole bit. Each run checks that the data pattern after the preamble appears intact in the bits the host samples on falling edges of `host_clk`. Short glitches are added inside data bits, and a long silence is used to drive the lock flag back down.

// File: rtl/bsync_pkg.sv
`timescale 1ns/1ps
package bsync_pkg;

  typedef struct packed {
    logic sync_on;
    logic tx_dir;
  } mode_t;

  function automatic logic near_boundary(input int ph, input int tol, input int os);
    return (ph <= tol) || (ph >= os - tol);
  endfunction

endpackage

// File: rtl/bsync_in_filter.sv
`timescale 1ns/1ps
module bsync_in_filter #(
  parameter int MAJ_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_bit,
  output logic filt_bit,
  output logic edge_seen
);
  localparam int MAJ_THR = MAJ_LEN / 2 + 1;

  logic [1:0]         sync_q;
  logic [MAJ_LEN-1:0] win_q;
  logic [MAJ_LEN-1:0] win_n;
  logic               vote;

  always_comb begin
    win_n = {win_q[MAJ_LEN-2:0], sync_q[1]};
    vote  = ($countones(win_n) >= MAJ_THR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      win_q     <= '0;
      filt_bit  <= 1'b0;
      edge_seen <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_bit};
      if (tick) begin
        win_q     <= win_n;
        filt_bit  <= vote;
        edge_seen <= (vote != filt_bit);
      end
    end
  end

  // R7: the filtered bit moves only on a sub-sample strobe
  p_filt_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_bit) |-> $past(tick));

endmodule

// File: rtl/bsync_phase_track.sv
`timescale 1ns/1ps
module bsync_phase_track #(
  parameter int OS_RATIO = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        nudge_en,
  input  logic                        edge_seen,
  input  logic                        restart,
  output logic [$clog2(OS_RATIO)-1:0] ph,
  output logic [$clog2(OS_RATIO)-1:0] ph_next,
  output logic                        boundary,
  output logic                        sample
);
  localparam int PH_W = $clog2(OS_RATIO);
  localparam logic [PH_W-1:0] MID_V = PH_W'(OS_RATIO / 2);
  localparam logic [PH_W-1:0] PRE_V = PH_W'(OS_RATIO / 2 - 1);

  logic          hold, jump;
  logic [1:0]    step;
  logic [PH_W:0] sum;

  always_comb begin
    hold     = nudge_en && edge_seen && (ph != '0) && (ph <= MID_V);
    jump     = nudge_en && edge_seen && (ph > MID_V);
    step     = hold ? 2'd0 : (jump ? 2'd2 : 2'd1);
    sum      = {1'b0, ph} + {{(PH_W-1){1'b0}}, step};
    boundary = tick && sum[PH_W];
    sample   = tick && !hold && (ph == PRE_V);
    if (!tick)        ph_next = ph;
    else if (restart) ph_next = '0;
    else              ph_next = sum[PH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_next;
  end

  // R3: every mid-bit sample leaves the counter at its mid count
  p_sample_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (ph == MID_V));

  // R9: a restart always lands on count 0
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && restart) |=> (ph == '0));

endmodule

// File: rtl/bsync_lock_det.sv
`timescale 1ns/1ps
module bsync_lock_det #(
  parameter int OS_RATIO   = 16,
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_EDGES = 8,
  parameter int LOSS_BITS  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        tick,
  input  logic                        edge_seen,
  input  logic                        boundary,
  input  logic [$clog2(OS_RATIO)-1:0] ph,
  output logic                        locked
);
  import bsync_pkg::*;

  localparam int CW = $clog2(LOCK_EDGES + 1);
  localparam int SW = $clog2(LOSS_BITS + 1);

  logic [CW-1:0] good_q;
  logic [SW-1:0] quiet_q;
  logic          in_win;
  logic          edge_ev;

  always_comb begin
    in_win  = near_boundary(int'(ph), LOCK_TOL, OS_RATIO);
    edge_ev = tick && edge_seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      good_q  <= '0;
      quiet_q <= '0;
      locked  <= 1'b0;
    end else if (edge_ev) begin
      quiet_q <= '0;
      if (in_win) begin
        if (good_q != CW'(LOCK_EDGES)) good_q <= good_q + 1'b1;
        if (good_q == CW'(LOCK_EDGES - 1)) locked <= 1'b1;
      end else begin
        good_q <= '0;
      end
    end else if (boundary) begin
      if (quiet_q != SW'(LOSS_BITS)) quiet_q <= quiet_q + 1'b1;
      if (quiet_q == SW'(LOSS_BITS - 1)) begin
        locked <= 1'b0;
        good_q <= '0;
      end
    end
  end

  // R8: lock is gained only on a well-placed edge
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_ev && in_win && !clear));

  // R8: lock is lost only through silence or leaving receive
  p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(clear || (boundary && !edge_ev)));

  p_quiet_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q <= SW'(LOSS_BITS));

endmodule

// File: rtl/bsync_data_if.sv
`timescale 1ns/1ps
module bsync_data_if #(
  parameter int OS_RATIO   = 16,
  parameter int MAJ_LEN    = 5,
  parameter int LOCK_TOL   = 2,
  parameter int LOCK_EDGES = 8,
  parameter int LOSS_BITS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic sync_en,
  input  logic tx_mode,
  input  logic host_tx_bit,
  output logic host_rx_bit,
  output logic host_clk,
  output logic mod_bit,
  input  logic demod_bit,
  output logic locked
);
  import bsync_pkg::*;

  localparam int PH_W = $clog2(OS_RATIO);

  mode_t            req, act_q, act_n;
  logic             filt_bit, edge_seen;
  logic [PH_W-1:0]  ph, ph_next;
  logic             boundary, sample, restart, rx_track;
  logic             tx_q, rx_q, clk_q;

  always_comb begin
    req.sync_on = sync_en;
    req.tx_dir  = tx_mode;
    restart     = boundary && (req != act_q);
    act_n       = boundary ? req : act_q;
    rx_track    = act_q.sync_on && !act_q.tx_dir;
  end

  bsync_in_filter #(.MAJ_LEN(MAJ_LEN)) u_filter (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .raw_bit(demod_bit),
    .filt_bit(filt_bit), .edge_seen(edge_seen)
  );

  bsync_phase_track #(.OS_RATIO(OS_RATIO)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .nudge_en(rx_track),
    .edge_seen(edge_seen), .restart(restart), .ph(ph), .ph_next(ph_next),
    .boundary(boundary), .sample(sample)
  );

  bsync_lock_det #(
    .OS_RATIO(OS_RATIO), .LOCK_TOL(LOCK_TOL),
    .LOCK_EDGES(LOCK_EDGES), .LOSS_BITS(LOSS_BITS)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .clear(!rx_track || restart), .tick(os_tick),
    .edge_seen(edge_seen), .boundary(boundary), .ph(ph), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      clk_q <= 1'b0;
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      act_q <= act_n;
      clk_q <= act_n.sync_on &
               (act_n.tx_dir ? ~ph_next[PH_W-1] : ph_next[PH_W-1]);
      if (boundary)             tx_q <= host_tx_bit;
      if (sample && rx_track)   rx_q <= filt_bit;
    end
  end

  always_comb begin
    host_clk    = clk_q;
    mod_bit     = !act_q.tx_dir ? 1'b0 : (act_q.sync_on ? tx_q : host_tx_bit);
    host_rx_bit = act_q.tx_dir ? 1'b0 : (act_q.sync_on ? rx_q : demod_bit);
  end

  // R1: no clock toward the host in transparent mode
  p_clk_low_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q.sync_on |-> !host_clk);

  // R2: timed transmit data moves only at a rising host clock
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.sync_on && act_q.tx_dir && $past(act_q.sync_on && act_q.tx_dir)
     && !$rose(host_clk)) |-> $stable(mod_bit));

  // R4: retimed receive data moves only at a rising host clock
  p_rx_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_track && $past(rx_track) && !$stable(host_rx_bit)) |-> $rose(host_clk));

  // R9: mode changes land at a bit boundary with the counter at 0
  p_mode_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> (ph == '0));

endmodule

// File: tb/test_bsync_data_if.sv
`timescale 1ns/1ps
module test_bsync_data_if;
  localparam logic [15:0] PAT = 16'hB3C5;
  localparam logic [9:0]  TXB = 10'b1101001110;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
  logic sync_en = 1'b0, tx_mode = 1'b0, host_tx_bit = 1'b0, demod_bit = 1'b0;
  logic host_rx_bit, host_clk, mod_bit, locked;

  int checks = 0, fails = 0, glitches = 0, rx_cnt = 0;
  bit done = 1'b0, collect = 1'b0, mon_on = 1'b0;
  logic rx_log [0:127];
  logic prev_rx = 1'b0, prev_clk = 1'b0;

  bsync_data_if i_bsync_data_if (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .sync_en(sync_en),
    .tx_mode(tx_mode), .host_tx_bit(host_tx_bit), .host_rx_bit(host_rx_bit),
    .host_clk(host_clk), .mod_bit(mod_bit), .demod_bit(demod_bit), .locked(locked)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  initial forever begin
    @(negedge clk);
    if (mon_on && (host_rx_bit !== prev_rx) && !(host_clk && !prev_clk)) glitches++;
    prev_rx  = host_rx_bit;
    prev_clk = host_clk;
  end

  initial forever begin
    @(negedge host_clk);
    #1;
    if (collect && rx_cnt < 128) begin
      rx_log[rx_cnt] = host_rx_bit;
      rx_cnt++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic s, input logic t);
    @(negedge clk);
    sync_en = s;
    tx_mode = t;
    repeat (40) @(negedge clk);
  endtask

  function automatic logic bitval(input int i, input int pre);
    if (i < pre) return logic'(i % 2);
    if (i < pre + 16) return PAT[15 - (i - pre)];
    return 1'b1;
  endfunction

  task automatic send_rx(input int period, input int idle, input int pre, input int glen);
    int acc = 0;
    int total = pre + 20;
    demod_bit = 1'b0;
    repeat (idle * 2) @(negedge clk);
    while (acc / period < total) begin
      int idx = acc / period;
      int sub = (acc % period) / 40;
      logic b = bitval(idx, pre);
      if (glen > 0 && idx >= pre && idx < pre + 16 && sub >= 4 && sub < 4 + glen) b = ~b;
      demod_bit = b;
      acc += 40;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_rx(input string req, input int period, input int idle,
                        input int pre, input int glen, input bit early);
    bit found = 1'b0;
    rx_cnt  = 0;
    collect = 1'b1;
    mon_on  = 1'b1;
    fork
      send_rx(period, idle, pre, glen);
      begin
        if (early) begin
          repeat (idle * 2 + 4 * 32) @(negedge clk);
          chk("R8", locked, 1'b0, "lock before 8 edges");
        end
      end
    join
    repeat (4 * 32) @(negedge clk);
    collect = 1'b0;
    for (int s = 0; s + 16 <= rx_cnt; s++) begin
      bit ok = 1'b1;
      for (int k = 0; k < 16; k++) if (rx_log[s + k] !== PAT[15 - k]) ok = 1'b0;
      if (ok) found = 1'b1;
    end
    checks++;
    if (!found) begin
      fails++;
      $display("FAIL %s data recovery (period %0d idle %0d pre %0d glitch %0d): actual pattern missing expected %h",
               req, period, idle, pre, glen, PAT);
    end
    chk("R8", locked, 1'b1, "locked after preamble");
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R10", host_clk, 1'b0, "host_clk in reset");
    chk("R10", mod_bit, 1'b0, "mod_bit in reset");
    chk("R10", locked, 1'b0, "locked in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", host_clk, 1'b0, "host_clk after reset");
    demod_bit = 1'b1; #1;
    chk("R10", host_rx_bit, 1'b1, "transparent receive after reset");
    demod_bit = 1'b0;
  endtask

  task automatic t_bypass;
    set_mode(1'b0, 1'b1);
    host_tx_bit = 1'b1; #1;
    chk("R1", mod_bit, 1'b1, "tx pass 1");
    host_tx_bit = 1'b0; #1;
    chk("R1", mod_bit, 1'b0, "tx pass 0");
    for (int k = 0; k < 4; k++) begin
      repeat (9) @(negedge clk);
      chk("R1", host_clk, 1'b0, "clock low in transparent tx");
    end
    set_mode(1'b0, 1'b0);
    host_tx_bit = 1'b1;
    demod_bit = 1'b1; #1;
    chk("R1", host_rx_bit, 1'b1, "rx pass 1");
    chk("R1", mod_bit, 1'b0, "modulator idle in receive");
    demod_bit = 1'b0; #1;
    chk("R1", host_rx_bit, 1'b0, "rx pass 0");
    chk("R1", host_clk, 1'b0, "clock low in transparent rx");
  endtask

  task automatic t_sync_tx;
    realtime t1 = 0.0, t2 = 0.0;
    host_tx_bit = TXB[0];
    @(negedge clk);
    sync_en = 1'b1;
    tx_mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge host_clk);
      if (i == 1) t1 = $realtime;
      if (i == 2) t2 = $realtime;
      @(negedge clk);
      chk("R2", mod_bit, TXB[i], "captured bit");
      host_tx_bit = ~TXB[i];
      @(negedge host_clk);
      #1;
      chk("R2", mod_bit, TXB[i], "bit held mid-period");
      if (i + 1 < 10) host_tx_bit = TXB[i + 1];
    end
    checks++;
    if ((t2 - t1) > 160.5 || (t2 - t1) < 159.5) begin
      fails++;
      $display("FAIL R2 host_clk period: actual %0t expected 160ns", t2 - t1);
    end
  endtask

  task automatic t_mode_change;
    logic old;
    @(posedge host_clk);
    repeat (3) @(negedge clk);
    old = mod_bit;
    sync_en = 1'b0;
    host_tx_bit = ~old;
    repeat (2) @(negedge clk);
    chk("R9", host_clk, 1'b1, "clock kept until boundary");
    chk("R9", mod_bit, old, "retimed bit kept until boundary");
    repeat (32) @(negedge clk);
    chk("R9", host_clk, 1'b0, "clock low after boundary");
    chk("R9", mod_bit, ~old, "transparent after boundary");
  endtask

  task automatic t_lock_loss;
    repeat (3 * 32) @(negedge clk);
    chk("R8", locked, 1'b1, "lock held through short silence");
    repeat (10 * 32) @(negedge clk);
    chk("R8", locked, 1'b0, "lock lost after 16 silent bits");
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_sync_tx();
    t_mode_change();
    set_mode(1'b1, 1'b0);
    run_rx("R3", 640, 5, 24, 0, 1'b1);
    t_lock_loss();
    run_rx("R5", 624, 3, 24, 0, 1'b0);
    run_rx("R5", 656, 7, 24, 0, 1'b0);
    for (int off = 0; off < 16; off += 4) run_rx("R6", 640, off, 22, 0, 1'b0);
    run_rx("R7", 640, 2, 24, 1, 1'b0);
    run_rx("R7", 640, 9, 24, 2, 1'b0);
    checks++;
    if (glitches != 0) begin
      fails++;
      $display("FAIL R4 receive data moved off a rising clock: actual %0d expected 0", glitches);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule